// File: doc/BRIEF.md
# Access Mode Screen and Interrupt Status Unit

This unit sits on the request path of a memory controller. Every access request carries an addressing-mode code. Two modes are accepted: linear incrementing and cache-line wrap. Any other code is rewritten so that the request carries on as a linear-incrementing access. The same request also raises a sticky error flag.

The unit holds the interrupt state for that error. A raw flag records every occurrence, whether or not the interrupt is enabled. A single enable bit gates the flag onto a level interrupt output. Software reaches this state through a small register port with four word slots:

| Slot | Meaning |
|------|---------|
| 0 | Raw flag |
| 1 | Gated flag |
| 2 | Enable-on |
| 3 | Enable-off |

Each slot has its own write strobe, and several strobes may be raised in one cycle. Reads are combinational on a slot index. Only bit 0 of a slot carries meaning, and all other read bits are zero.

Top module: `access_mode_screen`

## Requirements
- R1: A request with mode code 0 (linear incrementing) or 1 (cache-line wrap) leaves on `fwd_mode` unchanged, in the same cycle. `fwd_valid` always equals `req_valid`.
- R2: A request with mode code 2 or 3 leaves on `fwd_mode` as code 0, in the same cycle.
- R3: A valid request with mode code 2 or 3 sets the raw flag (slot 0, bit 0) at the next clock edge, whether or not the interrupt is enabled. An invalid request never sets the flag.
- R4: The gated flag (slot 1, bit 0) and `irq` both read 1 only when the raw flag and the enable bit are both 1. A write to slot 1 changes nothing.
- R5: Writing bit 0 = 1 to slot 2 sets the enable bit at the next edge. Slots 2 and 3 both read back the enable bit in bit 0.
- R6: Writing bit 0 = 1 to slot 3 clears the enable bit at the next edge.
- R7: Strobing slots 2 and 3 together with bit 0 = 1 leaves the enable bit at 0, so neither slot reads back 1.
- R8: Writing bit 0 = 1 to slot 0 clears the raw flag. Writing bit 0 = 0 there leaves the flag unchanged.
- R9: If a raw-flag clear and a new unsupported request arrive in the same cycle, the raw flag stays 1.
- R10: After reset the raw flag, the enable bit and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Incoming request valid |
| req_mode | input | MODE_W | Incoming addressing-mode code |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_mode | output | MODE_W | Forwarded addressing-mode code |
| reg_we | input | 4 | Per-slot write strobes |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | 2 | Read slot index |
| reg_rdata | output | DATA_W | Read data |
| irq | output | 1 | Level interrupt |

## Verification
Mode rewriting is combinational, so the bench checks `fwd_mode` a settling delay after it drives the request, in the same cycle. The raw flag and the enable bit change at the first rising edge after their stimulus. The bench therefore drives writes and requests at a falling edge and removes them at the next falling edge. It reads the slots and `irq` after that second falling edge, which is one register stage later. Read data is combinational, so each read is sampled a short delay after the slot index is set.

// File: rtl/ams_pkg.sv
package ams_pkg;

    localparam int SLOT_CNT  = 4;
    localparam int SLOT_W    = 2;
    localparam int SLOT_RAW  = 0;
    localparam int SLOT_GATE = 1;
    localparam int SLOT_ON   = 2;
    localparam int SLOT_OFF  = 3;

    typedef struct packed {
        logic raw;
        logic en;
    } irq_state_t;

endpackage

// File: rtl/ams_mode_screen.sv
module ams_mode_screen #(
    parameter int MODE_W      = 2,
    parameter int LINEAR_CODE = 0,
    parameter int WRAP_CODE   = 1
) (
    input  logic              in_valid,
    input  logic [MODE_W-1:0] in_mode,
    output logic              out_valid,
    output logic [MODE_W-1:0] out_mode,
    output logic              bad_mode
);
    localparam logic [MODE_W-1:0] LIN  = MODE_W'(LINEAR_CODE);
    localparam logic [MODE_W-1:0] WRAP = MODE_W'(WRAP_CODE);

    logic supported;

    always_comb begin
        supported = (in_mode == LIN) || (in_mode == WRAP);
        out_valid = in_valid;
        out_mode  = supported ? in_mode : LIN;
        bad_mode  = in_valid && !supported;
    end
endmodule

// File: rtl/ams_irq_next.sv
module ams_irq_next
    import ams_pkg::*;
(
    input  irq_state_t          cur,
    input  logic                err_hit,
    input  logic [SLOT_CNT-1:0] we,
    input  logic                wbit,
    output irq_state_t          nxt
);
    logic raw_clr, en_on, en_off;

    always_comb begin
        raw_clr = we[SLOT_RAW] && wbit;
        en_on   = we[SLOT_ON]  && wbit;
        en_off  = we[SLOT_OFF] && wbit;
        nxt     = cur;
        // A fresh error outranks a software clear.
        if (err_hit)      nxt.raw = 1'b1;
        else if (raw_clr) nxt.raw = 1'b0;
        // Off wins over on, so a joint write leaves the enable low.
        if (en_off)       nxt.en = 1'b0;
        else if (en_on)   nxt.en = 1'b1;
    end
endmodule

// File: rtl/ams_read_mux.sv
module ams_read_mux
    import ams_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  irq_state_t        st,
    input  logic [SLOT_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic flag;

    always_comb begin
        unique case (raddr)
            SLOT_W'(SLOT_RAW):  flag = st.raw;
            SLOT_W'(SLOT_GATE): flag = st.raw && st.en;
            default:            flag = st.en;
        endcase
    end

    generate
        if (DATA_W > 1) begin : g_wide
            assign rdata = {{(DATA_W-1){1'b0}}, flag};
        end else begin : g_narrow
            assign rdata = flag;
        end
    endgenerate
endmodule

// File: rtl/access_mode_screen.sv
module access_mode_screen
    import ams_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [MODE_W-1:0]   req_mode,
    output logic                fwd_valid,
    output logic [MODE_W-1:0]   fwd_mode,
    input  logic [SLOT_CNT-1:0] reg_we,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [SLOT_W-1:0]   reg_raddr,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq
);
    irq_state_t st_d, st_q;
    logic       bad_mode;

    ams_mode_screen #(.MODE_W(MODE_W)) u_screen (
        .in_valid (req_valid),
        .in_mode  (req_mode),
        .out_valid(fwd_valid),
        .out_mode (fwd_mode),
        .bad_mode (bad_mode)
    );

    ams_irq_next u_next (
        .cur    (st_q),
        .err_hit(bad_mode),
        .we     (reg_we),
        .wbit   (reg_wdata[0]),
        .nxt    (st_d)
    );

    ams_read_mux #(.DATA_W(DATA_W)) u_rmux (
        .st   (st_q),
        .raddr(reg_raddr),
        .rdata(reg_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.raw && st_q.en;
endmodule

// File: rtl/access_mode_screen_chk.sv
module access_mode_screen_chk #(
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [MODE_W-1:0] fwd_mode,
    input logic [MODE_W-1:0] req_mode,
    input logic [3:0]        reg_we,
    input logic              wbit,
    input logic              raw_q,
    input logic              en_q,
    input logic              irq
);
    // R2
    unsupported_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode > MODE_W'(1)) |-> (fwd_mode == '0));

    // R3
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode > MODE_W'(1)) |=> raw_q);

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_q && en_q));

    // R7
    joint_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we[3] && wbit) |=> !en_q);

    // R8
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_we[0] && wbit) && !(req_valid && req_mode > MODE_W'(1))) |=> (raw_q == $past(raw_q)));

    // R9
    err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we[0] && wbit && req_valid && req_mode > MODE_W'(1)) |=> raw_q);
endmodule

bind access_mode_screen access_mode_screen_chk #(.MODE_W(MODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .fwd_mode (fwd_mode),
    .req_mode (req_mode),
    .reg_we   (reg_we),
    .wbit     (reg_wdata[0]),
    .raw_q    (st_q.raw),
    .en_q     (st_q.en),
    .irq      (irq)
);

// File: tb/access_mode_screen_bench.sv
`timescale 1ns/1ps
module access_mode_screen_bench;
    localparam int MODE_W = 2;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [MODE_W-1:0] req_mode = '0;
    logic              fwd_valid;
    logic [MODE_W-1:0] fwd_mode;
    logic [3:0]        reg_we = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [1:0]        reg_raddr = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    access_mode_screen #(.MODE_W(MODE_W), .DATA_W(DATA_W)) u_access_mode_screen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .fwd_valid(fwd_valid), .fwd_mode(fwd_mode), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic rd(input int slot, output int val);
        reg_raddr = 2'(slot);
        #1;
        val = int'(reg_rdata);
    endtask

    // Drive strobes and a request for one edge, sample after the next falling edge.
    task automatic step(input logic [3:0] we, input int wd, input logic v, input int m);
        @(negedge clk);
        reg_we = we; reg_wdata = DATA_W'(wd); req_valid = v; req_mode = MODE_W'(m);
        @(negedge clk);
        reg_we = '0; reg_wdata = '0; req_valid = 1'b0; req_mode = '0;
        #1;
    endtask

    task automatic expect_state(input string req, input int raw, input int en);
        int v;
        rd(0, v); check({req, " raw slot"}, v, raw);
        rd(1, v); check({req, " gated slot"}, v, raw & en);
        rd(2, v); check({req, " on slot"}, v, en);
        rd(3, v); check({req, " off slot"}, v, en);
        check({req, " irq"}, int'(irq), raw & en);
    endtask

    task automatic t_reset();
        expect_state("R10", 0, 0);
    endtask

    task automatic t_pass_modes();
        @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            req_valid = 1'b1; req_mode = MODE_W'(m); #1;
            check("R1 valid passthrough", int'(fwd_valid), 1);
            check(m < 2 ? "R1 mode kept" : "R2 mode rewritten", int'(fwd_mode), m < 2 ? m : 0);
            req_valid = 1'b0; #1;
            check("R1 valid low", int'(fwd_valid), 0);
        end
        req_mode = '0;
        step(4'b0000, 0, 1'b1, 0);
        step(4'b0000, 0, 1'b1, 1);
        expect_state("R1 no flag", 0, 0);
        step(4'b0000, 0, 1'b0, 3);
        expect_state("R3 invalid ignored", 0, 0);
    endtask

    task automatic t_raw_set_and_clear();
        step(4'b0000, 0, 1'b1, 2);
        expect_state("R3 set while disabled", 1, 0);
        step(4'b0001, 0, 1'b0, 0);
        expect_state("R8 write zero", 1, 0);
        step(4'b0010, 1, 1'b0, 0);
        expect_state("R4 gated slot write", 1, 0);
        step(4'b0001, 1, 1'b0, 0);
        expect_state("R8 write one", 0, 0);
    endtask

    task automatic t_enable();
        step(4'b0100, 0, 1'b0, 0);
        expect_state("R5 zero data", 0, 0);
        step(4'b0100, 1, 1'b0, 0);
        expect_state("R5 on", 0, 1);
        step(4'b0000, 0, 1'b1, 3);
        expect_state("R4 gated", 1, 1);
        step(4'b1000, 1, 1'b0, 0);
        expect_state("R6 off", 1, 0);
        step(4'b0100, 1, 1'b0, 0);
        expect_state("R4 reenabled", 1, 1);
        step(4'b1100, 1, 1'b0, 0);
        expect_state("R7 joint", 1, 0);
        step(4'b1100, 1, 1'b0, 0);
        expect_state("R7 joint from off", 1, 0);
    endtask

    task automatic t_race();
        step(4'b0001, 1, 1'b1, 3);
        expect_state("R9 error beats clear", 1, 0);
        step(4'b0001, 1, 1'b0, 0);
        expect_state("R9 later clear", 0, 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        #1;
        t_reset();
        t_pass_modes();
        t_raw_set_and_clear();
        t_enable();
        t_race();
        done = 1'b1;
        finish_run();
    end
endmodule